// File: doc/BRIEF.md
# Upset-Tolerant Configuration Register Bank

This block holds a set of configuration words that must survive single-event upsets. Every bit is kept in three flip-flops, and the bank reads and drives out the two-of-three majority value. Whenever the three copies of a word disagree, each copy is loaded with the voted value at the next clock edge. A single upset therefore clears itself within one cycle and no outside action is needed.

Each word also carries one parity bit. The parity bit is computed when the word is written and is compared with the voted value on every cycle. A parity mismatch shows a fault that voting could not hide, such as two copies of one bit upset together or an upset parity bit. Such a fault raises a sticky per-word flag in a 32-bit status word. A saturating counter counts the cycles in which any copy disagreed. The OR of all status bits is driven out as one error line.

A test port can invert selected copies of one bit, or the parity bit, of one word. A bench uses it to exercise voting, scrubbing, parity detection and counting.

Top module: `seu_cfg_bank`

## Requirements
- R1: After reset every configuration word reads 0. The status word (address NUM_REGS) reads 0, the counter (address NUM_REGS+1) reads 0 and `err_o` is 0.
- R2: A write to an address below NUM_REGS loads the word at that clock edge. From the next cycle, the new value appears on `rd_data` (zero-extended, combinational on `rd_addr`) and in slice `[i*REG_W +: REG_W]` of `cfg_out`.
- R3: If only one of the three copies of a bit is inverted, the value read and driven out does not change.
- R4: At the edge after a disagreement appears, every copy is rewritten with the voted value. A later upset of a different copy of the same bit therefore leaves the word unchanged.
- R5: The counter (bits [CNT_W-1:0] at address NUM_REGS+1) rises by exactly one at each clock edge that ends a cycle in which any copy of any word disagreed. In all other cycles it holds its value.
- R6: Parity is even by default, so the stored bit equals the XOR of the data bits. When the voted word and its stored parity first disagree, status bit i is set at the next edge.
- R7: A status flag stays set until word i is written or `clr_flags` is pulsed. `clr_flags` clears all flags, and a flag that has been cleared stays clear while the same fault persists.
- R8: `err_o` is 1 exactly when any bit of the status word is 1.
- R9: A write to the status address, the counter address or an unmapped address changes no state.
- R10: The counter stops at 2^CNT_W-1. Status bit 31 is 1 while the counter is saturated.
- R11: If a write and an injection target the same word in the same cycle, the write takes effect and no disagreement follows.
- R12: Inverting only the parity bit sets the word's flag but does not advance the counter or change the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data (voted word, status or counter) |
| clr_flags | input | 1 | Clears all sticky parity flags |
| inj_en | input | 1 | Test injection strobe |
| inj_addr | input | ADDR_W | Word selected for injection |
| inj_bit | input | BIT_W | Bit position selected for injection |
| inj_copies | input | 3 | Mask of the copies to invert |
| inj_parity | input | 1 | Invert the stored parity bit |
| cfg_out | output | NUM_REGS*REG_W | All voted words, concatenated |
| err_o | output | 1 | OR of the status bits |

## Verification
Three kinds of injection are applied: one copy, two copies of the same bit, and the parity bit alone. Injecting one copy separates real voting from a design that reads a single copy. Injecting two copies separates correct parity detection from a design that never flags an error. Injecting the parity bit alone shows that the parity path is independent of the counter. Two upsets on different copies of the same bit, one cycle apart, show whether scrubbing happens between them. A long train of single upsets drives the counter into saturation. A write that collides with an injection, and writes to read-only addresses, check the priority order and the address decode.

// File: rtl/seu_bank_pkg.sv
package seu_bank_pkg;
   localparam int STATUS_W = 32;
   localparam int SAT_BIT  = 31;

   typedef enum logic [1:0] {
      AK_CFG    = 2'd0,
      AK_STATUS = 2'd1,
      AK_COUNT  = 2'd2,
      AK_NONE   = 2'd3
   } addr_kind_e;

   function automatic addr_kind_e classify(input int unsigned a, input int unsigned n);
      if (a < n)           return AK_CFG;
      else if (a == n)     return AK_STATUS;
      else if (a == n + 1) return AK_COUNT;
      else                 return AK_NONE;
   endfunction
endpackage

// File: rtl/seu_tmr_word.sv
module seu_tmr_word #(
   parameter int         W          = 16,
   parameter bit         ODD_PARITY = 1'b0,
   parameter logic [W-1:0] RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         flip_en,
   input  logic [2:0]   flip_mask,
   input  logic         flip_par,
   input  logic [W-1:0] flip_bits,
   output logic [W-1:0] voted,
   output logic         disagree,
   output logic         par_bad
);
   localparam bit RST_PAR = ODD_PARITY ? ~(^RST_VAL) : (^RST_VAL);

   logic [W-1:0] cp0, cp1, cp2;
   logic         par_q;
   logic         wr_par, vote_par;

   for (genvar k = 0; k < 3; k++) begin : g_copy
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= RST_VAL;
         else if (wr_en)                    q <= wr_data;
         else if (flip_en && flip_mask[k])  q <= voted ^ flip_bits;
         else                               q <= voted;
      end
   end

   assign cp0 = g_copy[0].q;
   assign cp1 = g_copy[1].q;
   assign cp2 = g_copy[2].q;

   assign voted    = (cp0 & cp1) | (cp1 & cp2) | (cp0 & cp2);
   assign disagree = |((cp0 ^ cp1) | (cp1 ^ cp2));

   if (ODD_PARITY) begin : g_odd
      assign wr_par   = ~(^wr_data);
      assign vote_par = ~(^voted);
   end else begin : g_even
      assign wr_par   = ^wr_data;
      assign vote_par = ^voted;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     par_q <= RST_PAR;
      else if (wr_en)                 par_q <= wr_par;
      else if (flip_en && flip_par)   par_q <= ~par_q;
   end

   assign par_bad = (vote_par != par_q);
endmodule

// File: rtl/seu_upset_counter.sv
module seu_upset_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   output logic [W-1:0] count,
   output logic         saturated
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   assign saturated = (count == MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (hit && !saturated) count <= count + W'(1);
   end
endmodule

// File: rtl/seu_status_collect.sv
module seu_status_collect import seu_bank_pkg::*; #(
   parameter int N = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        par_bad,
   input  logic [N-1:0]        wr_hit,
   input  logic                clr,
   input  logic                sat,
   output logic [STATUS_W-1:0] status,
   output logic                any_err
);
   localparam int PAD = STATUS_W - 1 - N;

   logic [N-1:0] flags_q, seen_q, rise;

   assign rise = par_bad & ~seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         seen_q  <= '0;
      end else begin
         seen_q  <= par_bad;
         flags_q <= (flags_q | rise) & ~(wr_hit | {N{clr}});
      end
   end

   assign status  = {sat, {PAD{1'b0}}, flags_q};
   assign any_err = |status;
endmodule

// File: rtl/seu_cfg_bank.sv
module seu_cfg_bank import seu_bank_pkg::*; #(
   parameter int NUM_REGS   = 8,
   parameter int REG_W      = 16,
   parameter int CNT_W      = 8,
   parameter bit ODD_PARITY = 1'b0,
   parameter int ADDR_W     = $clog2(NUM_REGS + 2),
   parameter int BIT_W      = (REG_W > 1) ? $clog2(REG_W) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [REG_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [STATUS_W-1:0]       rd_data,
   input  logic                      clr_flags,
   input  logic                      inj_en,
   input  logic [ADDR_W-1:0]         inj_addr,
   input  logic [BIT_W-1:0]          inj_bit,
   input  logic [2:0]                inj_copies,
   input  logic                      inj_parity,
   output logic [NUM_REGS*REG_W-1:0] cfg_out,
   output logic                      err_o
);
   if (NUM_REGS < 1 || NUM_REGS > 30) begin : g_bad_regs
      $error("NUM_REGS must lie in 1..30");
   end
   if (REG_W < 1 || REG_W > 32) begin : g_bad_width
      $error("REG_W must lie in 1..32");
   end
   if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
      $error("CNT_W must lie in 1..31");
   end
   if ((2 ** ADDR_W) < NUM_REGS + 2) begin : g_bad_addr
      $error("ADDR_W too small for the address map");
   end

   logic [NUM_REGS-1:0] wr_hit, inj_hit, disagree_w, par_bad_w;
   logic [REG_W-1:0]    voted_w [NUM_REGS];
   logic [REG_W-1:0]    flip_bits;
   logic                any_mismatch;
   logic [CNT_W-1:0]    cnt_w;
   logic                cnt_sat;
   logic [STATUS_W-1:0] status_w;

   assign flip_bits = REG_W'(1) << inj_bit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      assign wr_hit[i]  = wr_en  && (wr_addr  == ADDR_W'(i));
      assign inj_hit[i] = inj_en && (inj_addr == ADDR_W'(i));

      seu_tmr_word #(
         .W          (REG_W),
         .ODD_PARITY (ODD_PARITY),
         .RST_VAL    ('0)
      ) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_hit[i]),
         .wr_data   (wr_data),
         .flip_en   (inj_hit[i]),
         .flip_mask (inj_copies),
         .flip_par  (inj_parity),
         .flip_bits (flip_bits),
         .voted     (voted_w[i]),
         .disagree  (disagree_w[i]),
         .par_bad   (par_bad_w[i])
      );

      assign cfg_out[i*REG_W +: REG_W] = voted_w[i];
   end

   assign any_mismatch = |disagree_w;

   seu_upset_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (any_mismatch),
      .count     (cnt_w),
      .saturated (cnt_sat)
   );

   seu_status_collect #(.N(NUM_REGS)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .par_bad (par_bad_w),
      .wr_hit  (wr_hit),
      .clr     (clr_flags),
      .sat     (cnt_sat),
      .status  (status_w),
      .any_err (err_o)
   );

   always_comb begin
      rd_data = '0;
      unique case (classify(int'(rd_addr), NUM_REGS))
         AK_CFG: begin
            for (int i = 0; i < NUM_REGS; i++)
               if (rd_addr == ADDR_W'(i)) rd_data = STATUS_W'(voted_w[i]);
         end
         AK_STATUS: rd_data = status_w;
         AK_COUNT:  rd_data = STATUS_W'(cnt_w);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/seu_cfg_bank_chk.sv
module seu_cfg_bank_chk #(
   parameter int NUM_REGS = 8,
   parameter int REG_W    = 16,
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic                      clr_flags,
   input logic                      inj_en,
   input logic [NUM_REGS*REG_W-1:0] cfg_out,
   input logic                      err_o,
   input logic [31:0]               status_w,
   input logic [CNT_W-1:0]          cnt_w,
   input logic                      any_mismatch
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   // R3
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !inj_en && !any_mismatch) |=> $stable(cfg_out));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_mismatch && cnt_w != MAXV) |=> (cnt_w == $past(cnt_w) + CNT_W'(1)));

   // R5
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_mismatch |=> $stable(cnt_w));

   // R10
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_w == MAXV) |=> (cnt_w == MAXV));

   // R10
   sat_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_w == MAXV) |-> status_w[31]);

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clr_flags && !wr_en) |=> err_o);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_flag
      // R7
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (status_w[i] && !clr_flags && !(wr_en && wr_addr == ADDR_W'(i))) |=> status_w[i]);
   end
endmodule

bind seu_cfg_bank seu_cfg_bank_chk #(
   .NUM_REGS (NUM_REGS),
   .REG_W    (REG_W),
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .clr_flags    (clr_flags),
   .inj_en       (inj_en),
   .cfg_out      (cfg_out),
   .err_o        (err_o),
   .status_w     (status_w),
   .cnt_w        (cnt_w),
   .any_mismatch (any_mismatch)
);

// File: tb/tb_seu_cfg_bank.sv
module tb_seu_cfg_bank;
   localparam int NR  = 8;
   localparam int RW  = 16;
   localparam int CW  = 8;
   localparam int AW  = 4;
   localparam int BW  = 4;
   localparam int ST  = NR;
   localparam int CN  = NR + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [RW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic          clr_flags = 1'b0;
   logic          inj_en = 1'b0;
   logic [AW-1:0] inj_addr = '0;
   logic [BW-1:0] inj_bit = '0;
   logic [2:0]    inj_copies = '0;
   logic          inj_parity = 1'b0;
   logic [NR*RW-1:0] cfg_out;
   logic          err_o;

   always #10 clk = ~clk;

   seu_cfg_bank #(.NUM_REGS(NR), .REG_W(RW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .clr_flags(clr_flags), .inj_en(inj_en),
      .inj_addr(inj_addr), .inj_bit(inj_bit), .inj_copies(inj_copies),
      .inj_parity(inj_parity), .cfg_out(cfg_out), .err_o(err_o)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    n_chk = 0;
   int    n_fail = 0;
   int    exp_cnt = 0;

   // monitor: pops expected items and compares with the read port
   initial begin
      forever begin
         @(mon_ev);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (rd_data !== it.exp) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   task automatic expect_rd(input int a, input logic [31:0] e, input string tag);
      item_t it;
      rd_addr = AW'(a);
      #1;
      it.exp = e;
      it.tag = tag;
      q.push_back(it);
      ->mon_ev;
      #1;
   endtask

   task automatic expect_sig(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_chk++;
      if (act !== e) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, e);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_write(input int a, input logic [RW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_inject(input int a, input int b, input logic [2:0] m, input logic p);
      @(negedge clk);
      inj_en = 1'b1; inj_addr = AW'(a); inj_bit = BW'(b); inj_copies = m; inj_parity = p;
      @(negedge clk);
      inj_en = 1'b0; inj_copies = '0; inj_parity = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #4_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R1 reset state
      for (int i = 0; i < NR; i++) expect_rd(i, 32'h0, "R1 word after reset");
      expect_rd(ST, 32'h0, "R1 status after reset");
      expect_rd(CN, 32'h0, "R1 counter after reset");
      expect_sig(32'(err_o), 32'h0, "R1 err after reset");

      // R2 write and read back
      do_write(3, 16'hA5C3);
      do_write(5, 16'h1234);
      expect_rd(3, 32'h0000A5C3, "R2 readback word3");
      expect_rd(5, 32'h00001234, "R2 readback word5");
      expect_sig(32'(cfg_out[3*RW +: RW]), 32'h0000A5C3, "R2 cfg_out word3");

      // R9 writes to read-only and unmapped addresses
      do_write(ST, 16'hFFFF);
      do_write(CN, 16'hFFFF);
      do_write(12, 16'hFFFF);
      expect_rd(ST, 32'h0, "R9 status untouched");
      expect_rd(CN, 32'h0, "R9 counter untouched");
      expect_rd(3, 32'h0000A5C3, "R9 word3 untouched");
      expect_sig(32'(err_o), 32'h0, "R9 err untouched");

      // R3 single-copy flips, R5 counting
      do_inject(3, 0, 3'b001, 1'b0);
      expect_rd(3, 32'h0000A5C3, "R3 vote hides copy0 flip");
      expect_rd(CN, 32'(exp_cnt), "R5 counter before edge");
      tick(); exp_cnt++;
      expect_rd(CN, 32'(exp_cnt), "R5 counter after one upset");
      do_inject(3, 7, 3'b010, 1'b0);
      expect_rd(3, 32'h0000A5C3, "R3 vote hides copy1 flip");
      tick(); exp_cnt++;
      do_inject(3, 15, 3'b100, 1'b0);
      expect_rd(3, 32'h0000A5C3, "R3 vote hides copy2 flip");
      tick(); exp_cnt++;
      expect_rd(CN, 32'(exp_cnt), "R5 counter after three upsets");
      expect_rd(ST, 32'h0, "R3 no parity flag from single flips");

      // R4 scrub between two upsets of one bit
      do_inject(5, 4, 3'b001, 1'b0);
      do_inject(5, 4, 3'b010, 1'b0);
      expect_rd(5, 32'h00001234, "R4 scrub before second upset");
      tick(); exp_cnt += 2;
      expect_rd(CN, 32'(exp_cnt), "R4 counter two separate events");
      expect_rd(ST, 32'h0, "R4 no parity flag");

      // R6 / R8 two copies flipped
      do_inject(3, 2, 3'b011, 1'b0);
      expect_rd(3, 32'h0000A5C7, "R6 double flip wins vote");
      expect_rd(ST, 32'h0, "R6 flag not before edge");
      tick(); exp_cnt++;
      expect_rd(ST, 32'h00000008, "R6 flag for word3");
      expect_sig(32'(err_o), 32'h1, "R8 err follows flag");
      expect_rd(CN, 32'(exp_cnt), "R5 counter after double flip");

      // R7 sticky until write
      repeat (3) tick();
      expect_rd(ST, 32'h00000008, "R7 flag sticky");
      do_write(3, 16'hA5C3);
      expect_rd(ST, 32'h0, "R7 write clears flag");
      expect_sig(32'(err_o), 32'h0, "R8 err drops with status");
      expect_rd(3, 32'h0000A5C3, "R7 word3 rewritten");

      // R12 parity bit only
      do_inject(5, 0, 3'b000, 1'b1);
      tick();
      expect_rd(ST, 32'h00000020, "R12 parity flip flags word5");
      expect_rd(CN, 32'(exp_cnt), "R12 counter unchanged");
      expect_rd(5, 32'h00001234, "R12 data unchanged");
      expect_sig(32'(err_o), 32'h1, "R8 err on parity flag");

      // R7 clear command
      @(negedge clk); clr_flags = 1'b1;
      @(negedge clk); clr_flags = 1'b0;
      expect_rd(ST, 32'h0, "R7 clr clears flags");
      repeat (2) tick();
      expect_rd(ST, 32'h0, "R7 cleared flag stays clear");
      expect_sig(32'(err_o), 32'h0, "R8 err after clr");

      // R11 write beats injection
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(6); wr_data = 16'h0F0F;
      inj_en = 1'b1; inj_addr = AW'(6); inj_bit = BW'(0); inj_copies = 3'b111;
      @(negedge clk);
      wr_en = 1'b0; inj_en = 1'b0; inj_copies = '0;
      expect_rd(6, 32'h00000F0F, "R11 write wins");
      tick();
      expect_rd(CN, 32'(exp_cnt), "R11 no disagreement counted");
      expect_rd(ST, 32'h0, "R11 no parity flag");

      // R10 saturation
      for (int k = 0; k < 255; k++) do_inject(0, 1, 3'b001, 1'b0);
      tick();
      exp_cnt = (exp_cnt + 255 > 255) ? 255 : exp_cnt + 255;
      expect_rd(CN, 32'(exp_cnt), "R10 counter saturated");
      expect_rd(ST, 32'h80000000, "R10 saturation status bit");
      expect_sig(32'(err_o), 32'h1, "R8 err on saturation");
      do_inject(0, 1, 3'b100, 1'b0);
      tick();
      expect_rd(CN, 32'd255, "R10 counter holds at max");
      expect_rd(0, 32'h0, "R3 word0 intact after many upsets");

      summary();
      $finish;
   end
endmodule